// File: doc/BRIEF.md
# DMA Channel Register Bank and Completion Interrupts

This block holds the programming state of four DMA channels and one global operation register, all reached through a plain memory-mapped write port and a combinational read port. Each channel has four registers: a source address, a destination address, a transfer count and a control word. From these the block works out three things for each channel: whether it is enabled, whether it may run, and whether it starts on its own without an external request.

A transfer sequencer outside the block reports the end of a channel's transfer with a one-cycle event. That event sets the channel's done flag. If the channel's interrupt enable is set, the same clock edge also raises the channel's interrupt line. Software clears a pending interrupt by writing a control value that drops either the interrupt enable or the done flag. Moving data is left to the sequencer.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads as zero, and all of `irq`, `chan_en`, `chan_go`, `auto_go` and `glob_en` are low.
- R2: Only `addr[11:0]` is decoded, and `addr[1:0]` is ignored. Channel n owns the offsets n*16 + 0x0 (source), n*16 + 0x4 (destination), n*16 + 0x8 (count) and n*16 + 0xC (control). The operation register is at offset 0x40. Any other offset reads as zero, and a write to it changes nothing.
- R3: The count register keeps the low 24 bits written to it and reads back with bits 31:24 equal to zero.
- R4: `chan_en[n]` is high exactly when control bits 1:0 of channel n are 01. Bit 0 is the enable bit and bit 1 is the done flag.
- R5: `glob_en` is high exactly when bits 2:0 of the operation register are 001. The other bits of that register have no effect on it.
- R6: `chan_go[n]` is high when `chan_en[n]` and `glob_en` are both high.
- R7: `auto_go[n]` is high when `chan_go[n]` is high and the request-source field (control bits 11:8) holds a value from 4 to 7.
- R8: A pulse on `done_evt[n]` sets control bit 1 at the next clock edge. If control bit 2 (interrupt enable) is set after that edge, `irq[n]` rises at the same edge.
- R9: When the interrupt condition (bits 2 and 1 both set) holds before a control write and the written value breaks it, `irq[n]` falls at that write's edge.
- R10: A software write never raises `irq[n]`. A write that keeps the interrupt condition true leaves a pending `irq[n]` high. Events and writes on one channel leave the other channels' lines unchanged.
- R11: When a control write and `done_evt[n]` fall in the same cycle, the written value is stored with bit 1 forced to 1, and the interrupt follows R8 using the written bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address; only bits 11:0 are decoded |
| wr_en | input | 1 | Write strobe for `wdata` at `addr` |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| done_evt | input | N_CH | One-cycle transfer-end event per channel from the sequencer |
| chan_en | output | N_CH | Channel enabled and not yet done |
| chan_go | output | N_CH | Channel enabled while the controller is globally enabled |
| auto_go | output | N_CH | Runnable channel with an auto-request source |
| glob_en | output | 1 | Operation register low bits equal 001 |
| irq | output | N_CH | Per-channel completion interrupt |

## Verification
The bench builds the block with its defaults: four channels, 32-bit data, a 24-bit count and a 16-bit address. With a 16-bit address, an address whose upper nibble is not zero aliases onto the same registers, so the 12-bit decode can be checked directly. Writing all ones to the count register brings the 24-bit truncation into view. With four channels, the test can raise an event on one channel while it watches the lines of the others.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_CH-1:0]   done_evt,
  output logic [N_CH-1:0]   chan_en,
  output logic [N_CH-1:0]   chan_go,
  output logic [N_CH-1:0]   auto_go,
  output logic              glob_en,
  output logic [N_CH-1:0]   irq
);
  localparam int OFF_W   = 12;
  localparam int BANK_W  = OFF_W - 4;
  localparam int OPR_OFF = N_CH * 16;

  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] src_q [N_CH];
  logic [DATA_W-1:0] dst_q [N_CH];
  logic [CNT_W-1:0]  cnt_q [N_CH];
  logic [DATA_W-1:0] ctl_q [N_CH];
  logic              irq_q [N_CH];
  logic [DATA_W-1:0] opr_q;
  logic              opr_hit;

  assign off     = addr[OFF_W-1:0];
  assign opr_hit = (off[OFF_W-1:2] == OPR_OFF[OFF_W-1:2]);
  assign glob_en = (opr_q[2:0] == 3'b001);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 opr_q <= '0;
    else if (wr_en && opr_hit)  opr_q <= wdata;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic              hit, ctl_wr, was_act, now_act;
    logic [DATA_W-1:0] ctl_nx;

    assign hit     = wr_en && (off[OFF_W-1:4] == BANK_W'(i));
    assign ctl_wr  = hit && (off[3:2] == 2'd3);
    assign was_act = ctl_q[i][2] && ctl_q[i][1];
    assign now_act = wdata[2] && wdata[1];
    assign ctl_nx  = (ctl_wr ? wdata : ctl_q[i]) | (done_evt[i] ? DATA_W'(2) : '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
        ctl_q[i] <= '0;
        irq_q[i] <= 1'b0;
      end else begin
        if (hit && off[3:2] == 2'd0) src_q[i] <= wdata;
        if (hit && off[3:2] == 2'd1) dst_q[i] <= wdata;
        if (hit && off[3:2] == 2'd2) cnt_q[i] <= wdata[CNT_W-1:0];
        ctl_q[i] <= ctl_nx;
        if (done_evt[i] && ctl_nx[2])             irq_q[i] <= 1'b1;
        else if (ctl_wr && was_act && !now_act)   irq_q[i] <= 1'b0;
      end

    assign irq[i]     = irq_q[i];
    assign chan_en[i] = (ctl_q[i][1:0] == 2'b01);
    assign chan_go[i] = chan_en[i] && glob_en;
    assign auto_go[i] = chan_go[i] && (ctl_q[i][11:10] == 2'b01);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++)
      if (off[OFF_W-1:4] == BANK_W'(i))
        case (off[3:2])
          2'd0:    rdata = src_q[i];
          2'd1:    rdata = dst_q[i];
          2'd2:    rdata = DATA_W'(cnt_q[i]);
          default: rdata = ctl_q[i];
        endcase
    if (opr_hit) rdata = opr_q;
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [N_CH-1:0]   done_evt,
  input logic [N_CH-1:0]   irq,
  input logic [DATA_W-1:0] ctl_q [N_CH]
);
  for (genvar i = 0; i < N_CH; i++) begin : g_a
    logic ctl_sel, cnt_sel;
    assign ctl_sel = (addr[11:2] == 10'(i * 4 + 3));
    assign cnt_sel = (addr[11:2] == 10'(i * 4 + 2));

    a_r8_irq_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (ctl_q[i][2] && ctl_q[i][1]));
    a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt[i] |=> ctl_q[i][1]);
    a_r10_rise_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(done_evt[i]));
    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && wr_en && ctl_sel && !(wdata[2] && wdata[1]) && !done_evt[i]) |=> !irq[i]);
    a_r3_count_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_sel |-> (rdata[DATA_W-1:24] == '0));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .done_evt(done_evt), .irq(irq), .ctl_q(ctl_q)
);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  done_evt = '0, chan_en, chan_go, auto_go, irq;
  logic        glob_en;
  int nvec = 0, nbad = 0;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .done_evt(done_evt), .chan_en(chan_en), .chan_go(chan_go),
    .auto_go(auto_go), .glob_en(glob_en), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 16'h40; a += 4) begin
      rd(16'(a), d); chk("R1 reset read", d, 0);
    end
    chk("R1 reset outs", {irq, chan_en, chan_go, auto_go, 3'b0, glob_en}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      wr(16'(c*16),     32'h1000_0000 + c);
      wr(16'(c*16 + 4), 32'h2000_0000 + c);
    end
    for (int c = 0; c < 4; c++) begin
      rd(16'(c*16), d);     chk("R2 src", d, 32'h1000_0000 + c);
      rd(16'(c*16 + 4), d); chk("R2 dst", d, 32'h2000_0000 + c);
    end
    rd(16'hF010, d); chk("R2 alias", d, 32'h1000_0001);
    rd(16'h0016, d); chk("R2 low bits", d, 32'h2000_0001);
    wr(16'h0044, 32'hDEAD_BEEF);
    rd(16'h0044, d); chk("R2 unmapped", d, 0);
    wr(16'h0028, 32'hFFFF_FFFF);
    rd(16'h0028, d); chk("R3 count trunc", d, 32'h00FF_FFFF);
    wr(16'h0038, 32'hAB12_3456);
    rd(16'h0038, d); chk("R3 count", d, 32'h0012_3456);
  endtask

  task automatic t_global;
    logic [31:0] v [5] = '{32'h1, 32'h3, 32'h5, 32'h0, 32'h9};
    logic        e [5] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    for (int k = 0; k < 5; k++) begin
      wr(16'h0040, v[k]); #1 chk("R5 glob_en", glob_en, e[k]);
    end
  endtask

  task automatic t_enable;
    wr(16'h0040, 32'h0);
    wr(16'h000C, 32'h0001); #1 chk("R4 en", chan_en[0], 1);
    chk("R6 no glob", chan_go[0], 0);
    wr(16'h0040, 32'h1);    #1 chk("R6 go", chan_go[0], 1);
    chk("R7 src0 not auto", auto_go[0], 0);
    wr(16'h000C, 32'h0003); #1 chk("R4 done blocks", chan_en[0], 0);
    wr(16'h000C, 32'h0000); #1 chk("R4 off", chan_en[0], 0);
    wr(16'h001C, 32'h0401); #1 chk("R7 code4", auto_go[1], 1);
    wr(16'h001C, 32'h0701); #1 chk("R7 code7", auto_go[1], 1);
    wr(16'h001C, 32'h0801); #1 chk("R7 code8", auto_go[1], 0);
    wr(16'h001C, 32'h0301); #1 chk("R7 code3", auto_go[1], 0);
    wr(16'h001C, 32'h0000);
  endtask

  task automatic pulse(int c);
    @(negedge clk); done_evt[c] = 1'b1;
    @(negedge clk); done_evt[c] = 1'b0;
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(16'h002C, 32'h5);
    pulse(2);
    chk("R8 irq raise", irq, 4'b0100);
    rd(16'h002C, d); chk("R8 flag set", d, 32'h7);
    chk("R4 done clears en", chan_en[2], 0);
    wr(16'h002C, 32'h7); chk("R10 keep", irq[2], 1);
    wr(16'h002C, 32'h5); chk("R9 clear", irq[2], 0);
    wr(16'h003C, 32'h1);
    pulse(3);
    chk("R8 no ie", irq, 0);
    rd(16'h003C, d); chk("R8 flag no ie", d, 32'h3);
    wr(16'h003C, 32'h7); chk("R10 sw no raise", irq, 0);
    @(negedge clk); addr = 16'h003C; wdata = 32'h4; wr_en = 1'b1; done_evt[3] = 1'b1;
    @(negedge clk); wr_en = 1'b0; done_evt[3] = 1'b0;
    chk("R11 irq", irq, 4'b1000);
    rd(16'h003C, d); chk("R11 ctl", d, 32'h6);
    wr(16'h003C, 32'h4); chk("R9 drop te", irq, 0);
  endtask

  initial begin
    #(CLK_P*10);
    if (nvec < 1000000) begin end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_global();
        t_enable();
        t_irq();
      end
      begin
        repeat (20000) @(negedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule